// File: doc/BRIEF.md
# Bidirectional-Port Shift and Storage Register

This block is a register of `WIDTH` flip-flops (eight by default) that either keeps its contents, shifts toward the high end, shifts toward the low end, or takes a full word from a shared parallel port. A two-bit mode input selects the action. Every state change happens on the rising clock edge, and the mode, serial and parallel inputs are sampled at that edge.

The parallel port is bidirectional. On chip it is modelled as three signals: an input vector, an output-value vector and a single drive-enable. In load mode the port is only an input and is never driven. In every other mode the port shows the register contents, but only while both active-low enables are low. A synchronous active-low clear takes priority over every mode. The lowest and highest bits are always present on two dedicated serial outputs, and the enables do not affect them.

Top module: `shreg_core`

## Requirements
- R1: When `clr_n` is low at a rising edge, every register bit becomes 0 whatever `mode` is. If the port is then enabled and not in load mode, it shows all zeros in the following cycle.
- R2: With `clr_n` high and `mode` = 2'b00 (keep), the contents are unchanged at the edge.
- R3: With `mode` = 2'b01, `ser_lo` enters bit 0 and each bit n moves to bit n+1.
- R4: With `mode` = 2'b10, `ser_hi` enters bit WIDTH-1 and each bit n moves to bit n-1.
- R5: With `mode` = 2'b11, bit n of `pio_in` is stored into bit n.
- R6: `pio_drive` is 1 exactly when `en_a_n` and `en_b_n` are both 0 and `mode` is not 2'b11. While `pio_drive` is 1, bit n of `pio_out` equals register bit n in the same cycle, with no added latency.
- R7: With `mode` = 2'b11, `pio_drive` is 0 whatever the enables are.
- R8: `lsb_out` equals register bit 0 and `msb_out` equals bit WIDTH-1 at all times, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| mode | input | 2 | 00 keep, 01 shift up, 10 shift down, 11 parallel load |
| ser_lo | input | 1 | Serial bit entering bit 0 on an upward shift |
| ser_hi | input | 1 | Serial bit entering the top bit on a downward shift |
| en_a_n | input | 1 | Port enable A, active low |
| en_b_n | input | 1 | Port enable B, active low |
| pio_in | input | WIDTH | Value seen on the shared port pins |
| pio_out | output | WIDTH | Value driven onto the shared port |
| pio_drive | output | 1 | Port drive enable (1 = drive) |
| lsb_out | output | 1 | Register bit 0 |
| msb_out | output | 1 | Register bit WIDTH-1 |

## Verification
The bench drives a clear while the mode is load. A design that let load win over the clear would keep the loaded word. It runs every combination of the two enables with every mode, so a port that drove during load, or drove with only one enable low, would be reported in the same cycle. It checks the ends of both shift directions with alternating serial bits. A design that swapped the direction or dropped the entering bit would diverge from the behavioural model within one edge. It also checks that the port value follows the register in the very cycle after each edge, which catches an extra output stage.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shmode_e;
endpackage

// File: rtl/shreg_next.sv
module shreg_next
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  shmode_e          mode,
  input  logic             clr_n,
  input  logic             ser_lo,
  input  logic             ser_hi,
  input  logic [WIDTH-1:0] par,
  output logic [WIDTH-1:0] nxt
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] up_v;
  logic [WIDTH-1:0] down_v;

  // neighbour wiring for the two shift directions
  assign up_v[0]     = ser_lo;
  assign down_v[TOP] = ser_hi;
  for (genvar i = 1; i < WIDTH; i++) begin : g_up
    assign up_v[i] = cur[i-1];
  end
  for (genvar i = 0; i < TOP; i++) begin : g_down
    assign down_v[i] = cur[i+1];
  end

  always_comb begin
    if (!clr_n) begin
      nxt = '0;
    end else begin
      unique case (mode)
        MODE_UP:   nxt = up_v;
        MODE_DOWN: nxt = down_v;
        MODE_LOAD: nxt = par;
        default:   nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/shreg_port.sv
module shreg_port
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  shmode_e          mode,
  input  logic             en_a_n,
  input  logic             en_b_n,
  output logic [WIDTH-1:0] pio_out,
  output logic             pio_drive
);
  logic both_on;
  logic not_load;

  assign both_on   = ~(en_a_n | en_b_n);
  assign not_load  = (mode != MODE_LOAD);
  assign pio_drive = both_on & not_load;
  assign pio_out   = cur;
endmodule

// File: rtl/shreg_core.sv
module shreg_core
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic             ser_lo,
  input  logic             ser_hi,
  input  logic             en_a_n,
  input  logic             en_b_n,
  input  logic [WIDTH-1:0] pio_in,
  output logic [WIDTH-1:0] pio_out,
  output logic             pio_drive,
  output logic             lsb_out,
  output logic             msb_out
);
  localparam int TOP = WIDTH - 1;

  shmode_e          mode_e;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;

  assign mode_e = shmode_e'(mode);

  shreg_next #(.WIDTH(WIDTH)) u_next (
    .cur(q), .mode(mode_e), .clr_n(clr_n), .ser_lo(ser_lo),
    .ser_hi(ser_hi), .par(pio_in), .nxt(q_nxt)
  );

  always_ff @(posedge clk) q <= q_nxt;

  shreg_port #(.WIDTH(WIDTH)) u_port (
    .cur(q), .mode(mode_e), .en_a_n(en_a_n), .en_b_n(en_b_n),
    .pio_out(pio_out), .pio_drive(pio_drive)
  );

  assign lsb_out = q[0];
  assign msb_out = q[TOP];

  // R1: clear wins over every mode
  a_r1_clear: assert property (@(posedge clk) !clr_n |=> (pio_out == '0));
  // R2
  a_r2_keep: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b00) |=> $stable(pio_out));
  // R3
  a_r3_up: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b01) |=> (lsb_out == $past(ser_lo)));
  // R4
  a_r4_down: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b10) |=> (msb_out == $past(ser_hi)));
  // R5
  a_r5_load: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |=> (pio_out == $past(pio_in)));
  // R6: a single high enable always blocks the drive
  a_r6_enable: assert property (@(posedge clk) disable iff (!clr_n)
    (en_a_n || en_b_n) |-> !pio_drive);
  // R7
  a_r7_load_hiz: assert property (@(posedge clk) disable iff (!clr_n)
    (mode == 2'b11) |-> !pio_drive);
endmodule

// File: tb/tb_shreg_core.sv
`timescale 1ns/1ps
module tb_shreg_core;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         clr_n = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         ser_lo = 1'b0, ser_hi = 1'b0;
  logic         en_a_n = 1'b1, en_b_n = 1'b1;
  logic [W-1:0] pio_in = '0;
  logic [W-1:0] pio_out;
  logic         pio_drive, lsb_out, msb_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit model [W];
  bit done = 0;

  always #10 clk = ~clk;

  shreg_core #(.WIDTH(W)) dut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .ser_lo(ser_lo), .ser_hi(ser_hi),
    .en_a_n(en_a_n), .en_b_n(en_b_n), .pio_in(pio_in), .pio_out(pio_out),
    .pio_drive(pio_drive), .lsb_out(lsb_out), .msb_out(msb_out)
  );

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model[i];
    return v;
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare combinational outputs against the model for the present inputs
  task automatic compare(string tag);
    bit exp_drive;
    exp_drive = (en_a_n == 1'b0) && (en_b_n == 1'b0) && (mode != 2'b11);
    check(mode == 2'b11 ? "R7 drive" : "R6 drive", W'(pio_drive), W'(exp_drive));
    if (exp_drive) check({tag, " R6 port"}, pio_out, model_word());
    check("R8 lsb", W'(lsb_out), W'(model[0]));
    check("R8 msb", W'(msb_out), W'(model[W-1]));
  endtask

  // behavioural update at the clock edge
  task automatic advance();
    bit tmp [W];
    tmp = model;
    if (!clr_n) begin
      foreach (model[i]) model[i] = 0;
    end else if (mode == 2'b01) begin
      model[0] = ser_lo;
      for (int i = 1; i < W; i++) model[i] = tmp[i-1];
    end else if (mode == 2'b10) begin
      model[W-1] = ser_hi;
      for (int i = W - 2; i >= 0; i--) model[i] = tmp[i+1];
    end else if (mode == 2'b11) begin
      for (int i = 0; i < W; i++) model[i] = pio_in[i];
    end
  endtask

  task automatic step(bit c, logic [1:0] m, bit sl, bit sh, bit ea, bit eb,
                      logic [W-1:0] d, string tag);
    clr_n = c; mode = m; ser_lo = sl; ser_hi = sh;
    en_a_n = ea; en_b_n = eb; pio_in = d;
    #1 compare(tag);
    @(posedge clk);
    advance();
    @(negedge clk);
    #1 compare(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    @(negedge clk);
    // R1 reset state
    step(0, 2'b00, 0, 0, 0, 0, 8'h00, "R1");
    check("R1 reset", pio_out, 8'h00);
    // R5 load, port undriven even with enables low (R7)
    step(1, 2'b11, 0, 0, 0, 0, 8'hA5, "R5");
    check("R5 load", pio_out, 8'hA5);
    // R2 keep
    step(1, 2'b00, 1, 1, 0, 0, 8'hFF, "R2");
    check("R2 keep", pio_out, 8'hA5);
    // R3 shift up with alternating serial bits
    step(1, 2'b01, 1, 0, 0, 0, 8'h00, "R3");
    check("R3 up", pio_out, 8'h4B);
    step(1, 2'b01, 0, 1, 0, 0, 8'h00, "R3");
    check("R3 up", pio_out, 8'h96);
    // R4 shift down
    step(1, 2'b10, 0, 1, 0, 0, 8'h00, "R4");
    check("R4 down", pio_out, 8'hCB);
    step(1, 2'b10, 1, 0, 0, 0, 8'h00, "R4");
    check("R4 down", pio_out, 8'h65);
    // R1 clear beats load
    step(1, 2'b11, 0, 0, 0, 0, 8'h3C, "R5");
    step(0, 2'b11, 0, 0, 0, 0, 8'hFF, "R1");
    step(1, 2'b00, 0, 0, 0, 0, 8'h00, "R1");
    check("R1 clear over load", pio_out, 8'h00);
    // R6/R7 enable truth table with every mode
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++)
        step(1, m[1:0], e[0], e[1], e[0], e[1], 8'h5A ^ 8'(m * 17 + e), "R6");
    // mixed traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[4:0] != 0), r[6:5], r[7], r[8], r[9] & r[10], r[11] & r[12],
           r[20:13], "mix");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule